// File: doc/BRIEF.md
# Sector Header Search Unit

This unit finds the header of a wanted sector on a rotating track. It serves the sector read and sector write commands, and it also serves the command that reads back the next header. A front end supplies decoded bytes. Each header starts with a one-cycle flag that marks the header start and is followed by six header bytes:

- byte 0: track
- byte 1: side
- byte 2: sector
- byte 3: length code
- bytes 4 and 5: check bytes

After those bytes, a separate strobe reports whether the check bytes were correct. The unit compares the captured header against the current track number and against its own sector register. It can also compare the side bit. It gives up once a fixed number of index pulses has passed.

In search mode, a header that fully matches and has good check bytes raises a one-cycle match strobe and latches the length code for the data phase. The unit then waits for the data phase to report completion. In multi-sector mode it then advances its sector register and searches again, until the last sector of the track has been handled. In read-back mode, every header byte is handed out with a one-cycle data request. At the end, the captured track byte is copied into the sector register.

Top module: `sid_search`

## Requirements
- R1: After reset, busy, id_match, cmd_done, rnf, crc_err and drq are 0 and sec_reg is 0.
- R2: sec_ld loads sec_din into sec_reg only while the unit is idle. cmd_go is ignored while busy. sec_reg does not change while idle without sec_ld.
- R3: In search mode, a header whose track byte equals trk_reg and whose sector byte equals sec_reg (side rule per R5), followed by crc_vld with crc_ok=1, raises id_match for exactly one cycle, starting the cycle after crc_vld. len_code then holds the header's byte 3.
- R4: A header whose track byte or sector byte differs gives no id_match and no crc_err, and the search continues to the next header start.
- R5: With cmd_side_en=1 at cmd_go, bit 0 of the side byte must equal cmd_side. With cmd_side_en=0, the side byte has no effect.
- R6: A header that matches but arrives with crc_ok=0 sets crc_err and gives no id_match, and the search continues. crc_err stays set until the next accepted cmd_go.
- R7: While searching for the first sector of a command, the fifth index pulse without a match ends the command: cmd_done pulses, rnf becomes 1 and busy falls, all in the cycle after that pulse.
- R8: In single-sector mode, sector_done after a match pulses cmd_done and clears busy in the next cycle, and sec_reg is left unchanged.
- R9: In multi-sector mode, sector_done increments sec_reg and starts a new search, with a fresh index count, when sec_reg is below last_sec. Otherwise it ends the command with cmd_done.
- R10: In multi-sector mode, a search after an increment that times out on the fifth index pulse ends with cmd_done and leaves rnf at 0.
- R11: In read-back mode (cmd_rdaddr=1), each of the six bytes after a header start gives drq for one cycle, with drq_data equal to that byte. The following crc_vld sets crc_err to the inverse of crc_ok, copies the track byte into sec_reg and pulses cmd_done.
- R12: Bytes and crc_vld that arrive with no header start since the search began or since the last evaluated header are ignored: no drq, no id_match and no crc_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_go | input | 1 | Start pulse for a command |
| cmd_rdaddr | input | 1 | 1 selects read-back of the next header |
| cmd_multi | input | 1 | 1 selects multi-sector sequencing |
| cmd_side_en | input | 1 | 1 enables the side bit compare |
| cmd_side | input | 1 | Expected side bit |
| sec_ld | input | 1 | Sector register load strobe |
| sec_din | input | DW | Sector register load value |
| trk_reg | input | DW | Current track number |
| last_sec | input | DW | Highest sector number on the track |
| idam | input | 1 | Header-start flag |
| byte_vld | input | 1 | Decoded byte strobe |
| byte_data | input | DW | Decoded byte |
| crc_vld | input | 1 | End-of-header check strobe |
| crc_ok | input | 1 | Header check bytes were correct |
| idx_pulse | input | 1 | One-cycle index pulse |
| sector_done | input | 1 | Data phase of the matched sector finished |
| busy | output | 1 | A command is in progress |
| id_match | output | 1 | One-cycle match strobe |
| len_code | output | DW | Length code of the matched header |
| crc_err | output | 1 | Header check error seen |
| rnf | output | 1 | Header not found in time |
| cmd_done | output | 1 | One-cycle command end strobe |
| sec_reg | output | DW | Sector register |
| drq | output | 1 | Read-back byte available |
| drq_data | output | DW | Read-back byte |

## Verification
The assertions assume well-formed input framing from the front end. A header start never arrives in the same cycle as a byte. crc_vld only comes after the header's six bytes. Index pulses and sector_done last a single cycle, and sector_done is raised only after a match. The bench always drives one strobe at a time on the falling edge, with an idle cycle between strobes. Random header fields are drawn close to the reference values so that matches and each single-field mismatch both occur often.

// File: rtl/sid_pkg.sv
package sid_pkg;
   typedef enum logic [1:0] {
      ST_IDLE,
      ST_SEEK,
      ST_XFER,
      ST_RADR
   } sid_state_t;

   localparam int unsigned POS_TRK  = 0;
   localparam int unsigned POS_SIDE = 1;
   localparam int unsigned POS_SEC  = 2;
   localparam int unsigned POS_LEN  = 3;
endpackage

// File: rtl/sid_field_cmp.sv
module sid_field_cmp
   import sid_pkg::*;
#(
   parameter int unsigned DW         = 8,
   parameter int unsigned NB         = 6,
   parameter int unsigned PW         = 3,
   parameter bit          SIDE_CHECK = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          consume,
   input  logic          idam,
   input  logic          byte_vld,
   input  logic [DW-1:0] byte_data,
   input  logic [DW-1:0] trk_ref,
   input  logic [DW-1:0] sec_ref,
   input  logic          side_en,
   input  logic          side_ref,
   output logic          room,
   output logic          full,
   output logic          mism,
   output logic [DW-1:0] trk_q,
   output logic [DW-1:0] len_q
);
   localparam logic [PW-1:0] POS_END = PW'(NB);

   generate
      if (NB < POS_LEN + 1 || NB >= (1 << PW)) begin : g_bad_nb
         $error("sid_field_cmp: NB must hold the four fields and fit in PW bits");
      end
   endgenerate

   logic [PW-1:0] pos;
   logic          seen;
   logic [DW-1:0] cap_sec;
   logic          cap_side;
   logic          side_bad;

   assign room = seen && (pos != POS_END);
   assign full = seen && (pos == POS_END);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos      <= POS_END;
         seen     <= 1'b0;
         trk_q    <= '0;
         cap_side <= 1'b0;
         cap_sec  <= '0;
         len_q    <= '0;
      end else if (clr) begin
         pos  <= POS_END;
         seen <= 1'b0;
      end else if (idam) begin
         pos  <= '0;
         seen <= 1'b1;
      end else if (consume) begin
         seen <= 1'b0;
      end else if (byte_vld && room) begin
         pos <= pos + 1'b1;
         case (pos)
            PW'(POS_TRK):  trk_q    <= byte_data;
            PW'(POS_SIDE): cap_side <= byte_data[0];
            PW'(POS_SEC):  cap_sec  <= byte_data;
            PW'(POS_LEN):  len_q    <= byte_data;
            default: ;
         endcase
      end
   end

   generate
      if (SIDE_CHECK) begin : g_side
         assign side_bad = side_en && (cap_side != side_ref);
      end else begin : g_noside
         assign side_bad = 1'b0;
      end
   endgenerate

   assign mism = (trk_q != trk_ref) || (cap_sec != sec_ref) || side_bad;
endmodule

// File: rtl/sid_idx_timer.sv
module sid_idx_timer #(
   parameter int unsigned LIMIT = 5,
   localparam int unsigned CW   = $clog2(LIMIT + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic en,
   input  logic idx,
   output logic expire
);
   generate
      if (LIMIT < 1) begin : g_bad_limit
         $error("sid_idx_timer: LIMIT must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt;

   assign expire = en && idx && (cnt == CW'(LIMIT - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (clr)        cnt <= '0;
      else if (en && idx)  cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/sid_search.sv
module sid_search
   import sid_pkg::*;
#(
   parameter int unsigned DW         = 8,
   parameter int unsigned NB         = 6,
   parameter int unsigned IDX_LIMIT  = 5,
   parameter bit          SIDE_CHECK = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cmd_go,
   input  logic          cmd_rdaddr,
   input  logic          cmd_multi,
   input  logic          cmd_side_en,
   input  logic          cmd_side,
   input  logic          sec_ld,
   input  logic [DW-1:0] sec_din,
   input  logic [DW-1:0] trk_reg,
   input  logic [DW-1:0] last_sec,
   input  logic          idam,
   input  logic          byte_vld,
   input  logic [DW-1:0] byte_data,
   input  logic          crc_vld,
   input  logic          crc_ok,
   input  logic          idx_pulse,
   input  logic          sector_done,
   output logic          busy,
   output logic          id_match,
   output logic [DW-1:0] len_code,
   output logic          crc_err,
   output logic          rnf,
   output logic          cmd_done,
   output logic [DW-1:0] sec_reg,
   output logic          drq,
   output logic [DW-1:0] drq_data
);
   localparam int unsigned PW = $clog2(NB + 1);

   sid_state_t    st;
   logic          m_multi, m_side_en, m_side, stepped;
   logic          go_ok, step_ok, clr_hdr, searching, hdr_eval;
   logic          room, full, mism, expire;
   logic [DW-1:0] trk_q, len_q;

   assign busy      = (st != ST_IDLE);
   assign go_ok     = cmd_go && (st == ST_IDLE);
   assign step_ok   = (st == ST_XFER) && sector_done && m_multi && (sec_reg < last_sec);
   assign clr_hdr   = go_ok || step_ok;
   assign searching = (st == ST_SEEK) || (st == ST_RADR);
   assign hdr_eval  = searching && crc_vld && full;

   sid_field_cmp #(.DW(DW), .NB(NB), .PW(PW), .SIDE_CHECK(SIDE_CHECK)) u_cmp (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr_hdr),
      .consume  (hdr_eval),
      .idam     (idam),
      .byte_vld (byte_vld),
      .byte_data(byte_data),
      .trk_ref  (trk_reg),
      .sec_ref  (sec_reg),
      .side_en  (m_side_en),
      .side_ref (m_side),
      .room     (room),
      .full     (full),
      .mism     (mism),
      .trk_q    (trk_q),
      .len_q    (len_q)
   );

   sid_idx_timer #(.LIMIT(IDX_LIMIT)) u_idx (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr_hdr),
      .en    (searching),
      .idx   (idx_pulse),
      .expire(expire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         m_multi   <= 1'b0;
         m_side_en <= 1'b0;
         m_side    <= 1'b0;
         stepped   <= 1'b0;
         id_match  <= 1'b0;
         len_code  <= '0;
         crc_err   <= 1'b0;
         rnf       <= 1'b0;
         cmd_done  <= 1'b0;
         sec_reg   <= '0;
         drq       <= 1'b0;
         drq_data  <= '0;
      end else begin
         id_match <= 1'b0;
         cmd_done <= 1'b0;
         drq      <= 1'b0;
         case (st)
            ST_IDLE: begin
               if (sec_ld) sec_reg <= sec_din;
               if (cmd_go) begin
                  m_multi   <= cmd_multi;
                  m_side_en <= cmd_side_en;
                  m_side    <= cmd_side;
                  stepped   <= 1'b0;
                  crc_err   <= 1'b0;
                  rnf       <= 1'b0;
                  st        <= cmd_rdaddr ? ST_RADR : ST_SEEK;
               end
            end
            ST_SEEK: begin
               if (hdr_eval && !mism && crc_ok) begin
                  id_match <= 1'b1;
                  len_code <= len_q;
                  st       <= ST_XFER;
               end else begin
                  if (hdr_eval && !mism) crc_err <= 1'b1;
                  if (expire) begin
                     cmd_done <= 1'b1;
                     rnf      <= !stepped;
                     st       <= ST_IDLE;
                  end
               end
            end
            ST_XFER: begin
               if (step_ok) begin
                  sec_reg <= sec_reg + 1'b1;
                  stepped <= 1'b1;
                  st      <= ST_SEEK;
               end else if (sector_done) begin
                  cmd_done <= 1'b1;
                  st       <= ST_IDLE;
               end
            end
            ST_RADR: begin
               if (byte_vld && room && !idam) begin
                  drq      <= 1'b1;
                  drq_data <= byte_data;
               end
               if (hdr_eval) begin
                  crc_err  <= !crc_ok;
                  sec_reg  <= trk_q;
                  cmd_done <= 1'b1;
                  st       <= ST_IDLE;
               end else if (expire) begin
                  rnf      <= 1'b1;
                  cmd_done <= 1'b1;
                  st       <= ST_IDLE;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/sid_search_chk.sv
module sid_search_chk #(
   parameter int unsigned DW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          sec_ld,
   input logic          busy,
   input logic          id_match,
   input logic          rnf,
   input logic          cmd_done,
   input logic          drq,
   input logic [DW-1:0] sec_reg
);
   AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_done |-> !busy); // R8
   AST_MATCH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      id_match |=> !id_match); // R3
   AST_MATCH_IN_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      id_match |-> busy); // R3
   AST_RNF_ENDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rnf) |-> cmd_done); // R7
   AST_DRQ_IN_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      drq |-> busy); // R11
   AST_IDLE_SEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !sec_ld) |=> $stable(sec_reg)); // R2
   AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !$past(sec_ld) && !$stable(sec_reg)) |-> (sec_reg == $past(sec_reg) + 1'b1)); // R9
endmodule

bind sid_search sid_search_chk #(.DW(DW)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .sec_ld  (sec_ld),
   .busy    (busy),
   .id_match(id_match),
   .rnf     (rnf),
   .cmd_done(cmd_done),
   .drq     (drq),
   .sec_reg (sec_reg)
);

// File: tb/sid_search_tb.sv
module sid_search_tb;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_go = 0, cmd_rdaddr = 0, cmd_multi = 0, cmd_side_en = 0, cmd_side = 0;
   logic          sec_ld = 0;
   logic [DW-1:0] sec_din = '0, trk_reg = '0, last_sec = '0, byte_data = '0;
   logic          idam = 0, byte_vld = 0, crc_vld = 0, crc_ok = 0, idx_pulse = 0, sector_done = 0;
   logic          busy, id_match, crc_err, rnf, cmd_done, drq;
   logic [DW-1:0] len_code, sec_reg, drq_data;

   int n_chk = 0;
   int n_fail = 0;
   int cycles = 0;
   logic saw_match, saw_done, saw_drq;
   logic [DW-1:0] saw_data;

   always #2 clk = ~clk;

   sid_search u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_go(cmd_go), .cmd_rdaddr(cmd_rdaddr),
      .cmd_multi(cmd_multi), .cmd_side_en(cmd_side_en), .cmd_side(cmd_side),
      .sec_ld(sec_ld), .sec_din(sec_din), .trk_reg(trk_reg), .last_sec(last_sec),
      .idam(idam), .byte_vld(byte_vld), .byte_data(byte_data), .crc_vld(crc_vld),
      .crc_ok(crc_ok), .idx_pulse(idx_pulse), .sector_done(sector_done),
      .busy(busy), .id_match(id_match), .len_code(len_code), .crc_err(crc_err),
      .rnf(rnf), .cmd_done(cmd_done), .sec_reg(sec_reg), .drq(drq), .drq_data(drq_data)
   );

   task automatic chk(input logic ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
         finish_run();
      end
   end

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic go(input logic rd, input logic mu, input logic se, input logic sb);
      cmd_go = 1; cmd_rdaddr = rd; cmd_multi = mu; cmd_side_en = se; cmd_side = sb;
      @(negedge clk);
      cmd_go = 0; cmd_rdaddr = 0; cmd_multi = 0;
      @(negedge clk);
   endtask

   task automatic load_sec(input logic [DW-1:0] v);
      sec_ld = 1; sec_din = v;
      @(negedge clk);
      sec_ld = 0;
      @(negedge clk);
   endtask

   task automatic put_byte(input logic [DW-1:0] b);
      byte_vld = 1; byte_data = b;
      @(negedge clk);
      saw_drq = drq; saw_data = drq_data;
      byte_vld = 0;
      @(negedge clk);
   endtask

   task automatic put_crc(input logic ok);
      crc_vld = 1; crc_ok = ok;
      @(negedge clk);
      saw_match = id_match; saw_done = cmd_done;
      crc_vld = 0;
      @(negedge clk);
   endtask

   task automatic put_idx();
      idx_pulse = 1;
      @(negedge clk);
      saw_done = cmd_done;
      idx_pulse = 0;
      @(negedge clk);
   endtask

   task automatic put_sdone();
      sector_done = 1;
      @(negedge clk);
      saw_done = cmd_done;
      sector_done = 0;
      @(negedge clk);
   endtask

   task automatic header(input logic [DW-1:0] t, input logic [DW-1:0] s, input logic [DW-1:0] sc,
                         input logic [DW-1:0] ln, input logic ok);
      idam = 1;
      @(negedge clk);
      idam = 0;
      @(negedge clk);
      put_byte(t); put_byte(s); put_byte(sc); put_byte(ln); put_byte(8'hA5); put_byte(8'h5A);
      put_crc(ok);
   endtask

   function automatic logic exp_fields(input logic [DW-1:0] t, input logic [DW-1:0] s,
                                       input logic [DW-1:0] sc, input logic se, input logic sb,
                                       input logic [DW-1:0] tr, input logic [DW-1:0] sr);
      return (t == tr) && (sc == sr) && (!se || (s[0] == sb));
   endfunction

   initial begin
      logic [DW-1:0] hb [6];
      trk_reg = 8'd10; last_sec = 8'd9;
      idle(3);
      // R1 reset state
      chk(!busy && !id_match && !cmd_done && !rnf && !crc_err && !drq, "R1 reset flags", busy, 0);
      chk(sec_reg == 0, "R1 reset sec_reg", sec_reg, 0);
      rst_n = 1;
      idle(2);

      // R2 load while idle
      load_sec(8'd3);
      chk(sec_reg == 3, "R2 idle load", sec_reg, 3);

      // R12 bytes without header start are ignored
      go(0, 0, 0, 0);
      chk(busy, "R2 go accepted", busy, 1);
      put_byte(8'd10); put_byte(8'd0); put_byte(8'd3); put_byte(8'd2); put_byte(8'd0); put_byte(8'd0);
      put_crc(1);
      chk(!saw_match && !crc_err, "R12 no header start", saw_match, 0);
      // R3 matching header
      header(8'd10, 8'd1, 8'd3, 8'd2, 1);
      chk(saw_match, "R3 match strobe", saw_match, 1);
      chk(len_code == 2, "R3 length code", len_code, 2);
      chk(!id_match, "R3 one cycle", id_match, 0);
      // R2 ignored while busy
      sec_ld = 1; sec_din = 8'd77; cmd_go = 1; cmd_rdaddr = 1;
      @(negedge clk);
      sec_ld = 0; cmd_go = 0; cmd_rdaddr = 0;
      @(negedge clk);
      chk(sec_reg == 3, "R2 load ignored busy", sec_reg, 3);
      // R8 single sector end
      put_sdone();
      chk(saw_done && !busy, "R8 single done", saw_done, 1);
      chk(sec_reg == 3, "R8 sec unchanged", sec_reg, 3);

      // R4 mismatches then R7 timeout
      go(0, 0, 0, 0);
      header(8'd11, 8'd0, 8'd3, 8'd1, 1);
      chk(!saw_match && !crc_err, "R4 track mismatch", saw_match, 0);
      header(8'd10, 8'd0, 8'd4, 8'd1, 1);
      chk(!saw_match && !crc_err, "R4 sector mismatch", saw_match, 0);
      for (int i = 0; i < 4; i++) put_idx();
      chk(busy && !rnf, "R7 still busy after four", busy, 1);
      put_idx();
      chk(saw_done && rnf && !busy, "R7 rnf on fifth", rnf, 1);

      // R5 side compare
      go(0, 0, 1, 1);
      header(8'd10, 8'd2, 8'd3, 8'd1, 1);
      chk(!saw_match, "R5 side mismatch", saw_match, 0);
      header(8'd10, 8'd3, 8'd3, 8'd1, 1);
      chk(saw_match, "R5 side match", saw_match, 1);
      put_sdone();
      go(0, 0, 0, 1);
      header(8'd10, 8'd0, 8'd3, 8'd0, 1);
      chk(saw_match, "R5 side ignored", saw_match, 1);
      put_sdone();

      // R6 bad check bytes
      go(0, 0, 0, 0);
      header(8'd10, 8'd0, 8'd3, 8'd1, 0);
      chk(!saw_match && crc_err, "R6 crc error", crc_err, 1);
      header(8'd10, 8'd0, 8'd3, 8'd1, 1);
      chk(saw_match && crc_err, "R6 crc sticky", crc_err, 1);
      put_sdone();

      // R9 multi-sector stepping
      load_sec(8'd2); last_sec = 8'd4;
      go(0, 1, 0, 0);
      header(8'd10, 8'd0, 8'd2, 8'd1, 1);
      put_sdone();
      chk(!saw_done && busy && sec_reg == 3, "R9 step to 3", sec_reg, 3);
      header(8'd10, 8'd0, 8'd3, 8'd1, 1);
      chk(saw_match, "R9 match 3", saw_match, 1);
      put_sdone();
      chk(sec_reg == 4, "R9 step to 4", sec_reg, 4);
      header(8'd10, 8'd0, 8'd4, 8'd1, 1);
      put_sdone();
      chk(saw_done && !busy && sec_reg == 4, "R9 end at last", sec_reg, 4);

      // R10 failed search after increment
      load_sec(8'd1); last_sec = 8'd9;
      go(0, 1, 0, 0);
      header(8'd10, 8'd0, 8'd1, 8'd1, 1);
      put_sdone();
      for (int i = 0; i < 5; i++) put_idx();
      chk(saw_done && !rnf && !busy, "R10 normal end", rnf, 0);

      // R11 read-back
      go(1, 0, 0, 0);
      put_byte(8'h33);
      chk(!saw_drq, "R12 no drq before start", saw_drq, 0);
      hb = '{8'd21, 8'd1, 8'd7, 8'd3, 8'hC1, 8'h9E};
      idam = 1; @(negedge clk); idam = 0; @(negedge clk);
      for (int i = 0; i < 6; i++) begin
         put_byte(hb[i]);
         chk(saw_drq && saw_data == hb[i], "R11 byte out", saw_data, hb[i]);
      end
      put_crc(0);
      chk(saw_done && crc_err && sec_reg == 21, "R11 end", sec_reg, 21);

      // random single-sector searches
      for (int it = 0; it < 60; it++) begin
         logic [DW-1:0] t, s, sc, ln, sr;
         logic se, sb, ok, fm;
         sr = 8'($urandom_range(1, 9));
         load_sec(sr);
         trk_reg = 8'($urandom_range(0, 79));
         se = 1'($urandom); sb = 1'($urandom);
         t  = ($urandom_range(0, 3) == 0) ? trk_reg + 8'd1 : trk_reg;
         sc = ($urandom_range(0, 3) == 0) ? sr ^ 8'd1 : sr;
         s  = 8'($urandom_range(0, 3));
         ln = 8'($urandom_range(0, 3));
         ok = ($urandom_range(0, 3) != 0);
         fm = exp_fields(t, s, sc, se, sb, trk_reg, sr);
         go(0, 0, se, sb);
         header(t, s, sc, ln, ok);
         chk(saw_match == (fm && ok), "R3 R4 R5 random match", saw_match, fm && ok);
         chk(crc_err == (fm && !ok), "R6 random crc", crc_err, fm && !ok);
         if (fm && ok) begin
            chk(len_code == ln, "R3 random length", len_code, ln);
            put_sdone();
         end else begin
            for (int i = 0; i < 5; i++) put_idx();
            chk(rnf && !busy, "R7 random timeout", rnf, 1);
         end
      end
      finish_run();
   end
endmodule